// File: doc/BRIEF.md
# Vectored Interrupt Aggregator

This block gathers up to 32 interrupt lines from peripherals and turns them into a single request toward a processor. Each line is fixed at build time as edge-captured or level-captured by a parameter mask. Captured events are held in a status word. A software-written enable word selects which held events count as pending. A two-bit master control gates the final request.

Software works through a small word-addressed register port with eight registers. It can read the raw held events, the pending set and the enable word. It can clear held events by writing ones. It can set or clear single enable bits without a read-modify-write, using two alias registers. It can also read a vector register that names the lowest pending line. The register port is plain control with no back-pressure: a write is taken on every clock edge where `bus_we` is high, and read data is a combinational function of `bus_addr` with no side effects. No data stream passes through the block, so it has no valid/ready interface.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status, enable and master registers are zero, `irq_o` is low, and the vector register (byte offset 0x18) reads 0xFFFFFFFF.
- R2: An edge-captured line (its bit of `EDGE_MASK` is 1) sets its status bit (offset 0x00) on a low-to-high transition. The bit stays set after the line falls. Holding the line high after an acknowledge does not set the bit again.
- R3: A level-captured line (its bit of `EDGE_MASK` is 0) sets its status bit on every clock while the line is high. An acknowledge while the line is high has no lasting effect. An acknowledge after the line has fallen clears the bit.
- R4: Writing the acknowledge register (offset 0x0C) clears every status bit written as 1 and leaves bits written as 0 unchanged. Writing all ones clears every status bit. Reading offset 0x0C returns zero.
- R5: Writing the set-enable alias (offset 0x10) sets the enable bits written as 1 and leaves the others unchanged. Reading it returns zero.
- R6: Writing the clear-enable alias (offset 0x14) clears the enable bits written as 1 and leaves the others unchanged. Reading it returns zero.
- R7: Writing the enable register (offset 0x08) replaces the whole enable word, and reading it returns the stored value.
- R8: The pending register (offset 0x04) reads as status AND enable.
- R9: `irq_o` is high exactly when the master register (offset 0x1C) has bit 0 (request enable) and bit 1 (source enable) both set and at least one pending bit is set. The master register reads back its two bits.
- R10: The vector register returns the index of the lowest set pending bit, or 0xFFFFFFFF when no bit is pending.
- R11: Status capture does not depend on enable. A line held while disabled becomes pending as soon as its enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 5 | Byte address of the register; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | N_IN | Interrupt lines from peripherals, synchronous to `clk` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that `irq_in` is already synchronous to `clk`. An edge line is judged against its value at the previous edge, so a line that glitches between edges is outside what they model. They also assume that only one register write happens per cycle, since set-enable, clear-enable and acknowledge share the single write strobe. The bench keeps within these rules: it changes lines and the write strobe only on falling edges, holds every line low through reset so that no spurious edge is seen at release, and issues writes one at a time.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 5;

  // Word index within the register window, bus_addr[4:2]
  typedef enum logic [2:0] {
    W_STATUS  = 3'd0,
    W_PENDING = 3'd1,
    W_ENABLE  = 3'd2,
    W_ACK     = 3'd3,
    W_SETEN   = 3'd4,
    W_CLREN   = 3'd5,
    W_VECTOR  = 3'd6,
    W_MASTER  = 3'd7
  } reg_word_e;

  localparam int unsigned M_REQ_BIT = 0;  // request output enable
  localparam int unsigned M_SRC_BIT = 1;  // hardware source enable
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned N_IN      = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] irq_in,
  input  logic            ack_we,
  input  logic [N_IN-1:0] ack_bits,
  output logic [N_IN-1:0] status_o
);
  logic [N_IN-1:0] hit;
  logic [N_IN-1:0] clr;

  for (genvar g = 0; g < N_IN; g++) begin : g_bit
    if (EDGE_MASK[g]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= irq_in[g];
      end
      assign hit[g] = irq_in[g] & ~prev_q;
    end else begin : g_level
      assign hit[g] = irq_in[g];
    end
  end

  assign clr = ack_we ? ack_bits : '0;

  // New events win over an acknowledge in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= (status_o & ~clr) | hit;
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_IN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  reg_word_e         sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [N_IN-1:0]   enable_o,
  output logic [1:0]        master_o
);
  logic [N_IN-1:0] wbits;
  assign wbits = wdata[N_IN-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_o <= '0;
    end else if (we) begin
      unique case (sel)
        W_ENABLE: enable_o <= wbits;
        W_SETEN:  enable_o <= enable_o | wbits;
        W_CLREN:  enable_o <= enable_o & ~wbits;
        default:  enable_o <= enable_o;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      master_o <= 2'b00;
    else if (we && sel == W_MASTER)  master_o <= wdata[1:0];
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N_IN  = 32,
  localparam int unsigned IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic [N_IN-1:0]  req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // Scan from the top so the lowest set index is the last one written.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_IN      = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_IN-1:0]   irq_in,
  output logic              irq_o
);
  localparam int unsigned IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;

  reg_word_e         sel;
  logic [N_IN-1:0]   status_q;
  logic [N_IN-1:0]   enable_q;
  logic [N_IN-1:0]   pending;
  logic [1:0]        master_q;
  logic              vec_found;
  logic [IDX_W-1:0]  vec_idx;
  logic [DATA_W-1:0] vec_word;
  logic              ack_we;
  logic              unused_ok;

  assign sel       = reg_word_e'(bus_addr[4:2]);
  assign unused_ok = ^bus_addr[1:0];
  assign ack_we    = bus_we && (sel == W_ACK);

  irq_capture #(.N_IN(N_IN), .EDGE_MASK(EDGE_MASK)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .ack_we   (ack_we),
    .ack_bits (bus_wdata[N_IN-1:0]),
    .status_o (status_q)
  );

  irq_ctrl_regs #(.N_IN(N_IN)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (bus_we),
    .sel      (sel),
    .wdata    (bus_wdata),
    .enable_o (enable_q),
    .master_o (master_q)
  );

  assign pending = status_q & enable_q;

  irq_prio_enc #(.N_IN(N_IN)) u_enc (
    .req   (pending),
    .found (vec_found),
    .idx   (vec_idx)
  );

  assign vec_word = vec_found ? DATA_W'(vec_idx) : '1;
  assign irq_o    = master_q[M_REQ_BIT] & master_q[M_SRC_BIT] & (|pending);

  always_comb begin
    unique case (sel)
      W_STATUS:  bus_rdata = DATA_W'(status_q);
      W_PENDING: bus_rdata = DATA_W'(pending);
      W_ENABLE:  bus_rdata = DATA_W'(enable_q);
      W_VECTOR:  bus_rdata = vec_word;
      W_MASTER:  bus_rdata = DATA_W'(master_q);
      default:   bus_rdata = '0;  // write-only aliases read as zero
    endcase
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_IN      = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [N_IN-1:0]   irq_in,
  input logic              irq_o,
  input logic [N_IN-1:0]   status_q,
  input logic [N_IN-1:0]   enable_q,
  input logic [1:0]        master_q,
  input logic [DATA_W-1:0] vec_word
);
  localparam logic [N_IN-1:0] EM  = EDGE_MASK[N_IN-1:0];
  localparam logic [N_IN-1:0] LVL = ~EM;

  logic [2:0] w;
  assign w = bus_addr[4:2];

  // R9: the request needs both master bits
  a_r9_req_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (master_q == 2'b11));

  // R9: the request needs something pending
  a_r9_req_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((status_q & enable_q) != '0));

  // R4 / R2: an acked edge bit with no new rising edge is clear afterwards
  a_r4_ack_clears_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && w == 3'd3) |=>
      ((status_q & $past(bus_wdata[N_IN-1:0]) & EM & ~$past(irq_in)) == '0));

  // R3: a high level line is held in status regardless of acknowledge
  a_r3_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((status_q & $past(irq_in & LVL)) == $past(irq_in & LVL)));

  // R5: set-enable alias sets the written ones
  a_r5_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && w == 3'd4) |=>
      ((enable_q & $past(bus_wdata[N_IN-1:0])) == $past(bus_wdata[N_IN-1:0])));

  // R6: clear-enable alias clears the written ones
  a_r6_clr_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && w == 3'd5) |=> ((enable_q & $past(bus_wdata[N_IN-1:0])) == '0));

  // R7: direct enable write replaces the word
  a_r7_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && w == 3'd2) |=> (enable_q == $past(bus_wdata[N_IN-1:0])));

  // R10: nothing pending reads as all ones
  a_r10_vector_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & enable_q) == '0) |-> (vec_word == '1));
endmodule

bind irq_aggregator irq_aggregator_chk #(.N_IN(N_IN), .EDGE_MASK(EDGE_MASK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_in    (irq_in),
  .irq_o     (irq_o),
  .status_q  (status_q),
  .enable_q  (enable_q),
  .master_q  (master_q),
  .vec_word  (vec_word)
);

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;
  localparam int unsigned N = 32;
  localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_EN = 5'h08,
                         A_ACK = 5'h0C, A_SET = 5'h10, A_CLR = 5'h14,
                         A_VEC = 5'h18, A_MST = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_in = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_aggregator #(.N_IN(N), .EDGE_MASK(32'h0000_FFFF)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [4:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [N-1:0] lines);
    @(negedge clk); irq_in = irq_in | lines;
    @(negedge clk); irq_in = irq_in & ~lines;
  endtask

  task automatic t_reset;
    rd_check("R1 status", A_STAT, 32'h0);
    rd_check("R1 enable", A_EN, 32'h0);
    rd_check("R1 master", A_MST, 32'h0);
    rd_check("R1 vector", A_VEC, 32'hFFFF_FFFF);
    check("R1 irq_o", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_edge;
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk);
    rd_check("R2 edge latched", A_STAT, 32'h8);
    irq_in[3] = 1'b0;
    @(negedge clk);
    rd_check("R2 held after fall", A_STAT, 32'h8);
    wr(A_ACK, 32'h8);
    rd_check("R2 acked", A_STAT, 32'h0);
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk);
    wr(A_ACK, 32'h8);
    @(negedge clk);
    rd_check("R2 no retrigger while high", A_STAT, 32'h0);
    irq_in[3] = 1'b0;
  endtask

  task automatic t_level;
    @(negedge clk); irq_in[20] = 1'b1;
    @(negedge clk);
    rd_check("R3 level set", A_STAT, 32'h0010_0000);
    wr(A_ACK, 32'h0010_0000);
    rd_check("R3 ack while high", A_STAT, 32'h0010_0000);
    irq_in[20] = 1'b0;
    wr(A_ACK, 32'h0010_0000);
    rd_check("R3 ack after fall", A_STAT, 32'h0);
  endtask

  task automatic t_ack;
    pulse(32'h28);
    rd_check("R4 two captured", A_STAT, 32'h28);
    wr(A_ACK, 32'h8);
    rd_check("R4 partial ack", A_STAT, 32'h20);
    rd_check("R4 ack reads zero", A_ACK, 32'h0);
    wr(A_ACK, 32'hFFFF_FFFF);
    rd_check("R4 ack all", A_STAT, 32'h0);
  endtask

  task automatic t_enable;
    wr(A_EN, 32'h0000_00F0);
    rd_check("R7 enable readback", A_EN, 32'h0000_00F0);
    wr(A_SET, 32'h0000_0003);
    rd_check("R5 set alias", A_EN, 32'h0000_00F3);
    rd_check("R5 set reads zero", A_SET, 32'h0);
    wr(A_CLR, 32'h0000_0030);
    rd_check("R6 clear alias", A_EN, 32'h0000_00C3);
    rd_check("R6 clear reads zero", A_CLR, 32'h0);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_master_vector;
    wr(A_MST, 32'h3);
    pulse(32'h22);
    rd_check("R11 captured while disabled", A_STAT, 32'h22);
    rd_check("R8 pending none", A_PEND, 32'h0);
    rd_check("R10 vector idle", A_VEC, 32'hFFFF_FFFF);
    check("R9 no irq without pending", {31'h0, irq_o}, 32'h0);
    wr(A_EN, 32'h20);
    rd_check("R8 pending masked", A_PEND, 32'h20);
    rd_check("R11 late enable", A_VEC, 32'd5);
    check("R9 irq on", {31'h0, irq_o}, 32'h1);
    wr(A_SET, 32'h2);
    rd_check("R10 lowest index", A_VEC, 32'd1);
    wr(A_MST, 32'h1);
    check("R9 source disabled", {31'h0, irq_o}, 32'h0);
    wr(A_MST, 32'h2);
    check("R9 request disabled", {31'h0, irq_o}, 32'h0);
    rd_check("R9 master readback", A_MST, 32'h2);
    wr(A_MST, 32'h3);
    check("R9 both set", {31'h0, irq_o}, 32'h1);
    wr(A_CLR, 32'h22);
    check("R9 off after clear", {31'h0, irq_o}, 32'h0);
    rd_check("R10 idle again", A_VEC, 32'hFFFF_FFFF);
    wr(A_ACK, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_edge();
    t_level();
    t_ack();
    t_enable();
    t_master_vector();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule